// File: doc/BRIEF.md
# Serial Parity Slot Inserter

This block sits on a one-bit-per-clock serial path whose stream is cut into fixed frames. Each frame has `DATA_BITS` data slots followed by one reserved slot that the sender leaves empty. The block forwards the data slots unchanged to its output. In the reserved slot it writes the even parity of that frame's data bits, so the receiver sees a complete word with its check bit.

The state is a slot counter plus one running-parity bit, held as the most significant bit of the state. By default the output is chosen combinationally. In the data slots it is the live input, and in the reserved slot it is the parity bit. A parameter adds one output flop. That flop removes glitches that follow the input, and it costs one clock of latency.

Frames follow each other with no gap. Reset always realigns the block to the first slot of a frame.

Top module: `serial_parity_inserter`

## Requirements
- R1: A frame is `DATA_BITS`+1 slots long. After the last slot the next clock starts a new frame at slot 0, with no idle cycle. The first clock after reset is slot 0.
- R2: In live mode (`OUT_MODE` = `OUT_LIVE`), during slots 0 to `DATA_BITS`-1, `y_o` equals `x_i` in the same cycle.
- R3: In live mode, during slot `DATA_BITS`, `y_o` equals the XOR of the data bits received in slots 0 to `DATA_BITS`-1 of that frame. Data all zero gives 0, and a single one gives 1.
- R4: The running parity is cleared at the start of every frame. The parity slot depends only on the current frame's data bits.
- R5: The value on `x_i` during the parity slot is ignored. It changes neither the output nor the parity of any later frame.
- R6: While `rst_ni` is low (asynchronous, active low), the block sits at slot 0 with parity 0. In clocked mode the output register reads 0. Any state code that cannot be reached from reset returns to that reset state on the next clock.
- R7: In clocked mode (`OUT_MODE` = `OUT_CLOCKED`), `y_o` equals, one clock later, the value that live mode would drive for the same stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one bit time per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial input with empty parity slots |
| y_o | output | 1 | Serial output with parity slots filled |

## Verification
The bench builds two copies with the default three data bits, one with `OUT_MODE` = `OUT_LIVE` and one with `OUT_MODE` = `OUT_CLOCKED`, and feeds them the same stream. Comparing the two copies against one model checks the combinational forwarding, the parity fill and the one-clock shift of the registered variant against each other. The streams cover all eight data patterns back to back, with both values on the ignored slot, plus pseudo-random frames. A reset in the middle of a frame shows that the block realigns to slot 0.

// File: rtl/parins_pkg.sv
package parins_pkg;
  typedef enum logic {
    OUT_LIVE    = 1'b0,
    OUT_CLOCKED = 1'b1
  } out_mode_e;
endpackage

// File: rtl/parins_state.sv
module parins_state #(
  parameter int unsigned DATA_BITS = 3,
  localparam int unsigned SLOT_W = $clog2(DATA_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              par_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(DATA_BITS);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              par_q, par_d;

  always_comb begin
    slot_d = slot_q + SLOT_W'(1);
    par_d  = par_q ^ x_i;
    if (slot_q == '0) begin
      if (par_q) begin          // unreachable code: back to reset state
        slot_d = '0;
        par_d  = 1'b0;
      end else begin
        par_d  = x_i;           // parity cleared at frame start
      end
    end else if (slot_q >= LAST) begin
      slot_d = '0;              // parity slot input dropped
      par_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      par_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      par_q  <= par_d;
    end
  end

  assign slot_o = slot_q;
  assign par_o  = par_q;
  assign last_o = (slot_q == LAST);

  assert_slot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q < LAST && !(slot_q == '0 && par_q)) |=> slot_q == $past(slot_q) + SLOT_W'(1));
  assert_slot_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == LAST) |=> slot_q == '0);
  assert_par_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == '0 && !par_q) |=> par_q == $past(x_i));
  assert_par_accum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != '0 && slot_q < LAST) |=> par_q == ($past(par_q) ^ $past(x_i)));
  assert_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == LAST) |=> !par_q);
  assert_recover_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == '0 && par_q) |=> (slot_q == '0 && !par_q));
endmodule

// File: rtl/parins_out_sel.sv
module parins_out_sel
  import parins_pkg::*;
#(
  parameter out_mode_e OUT_MODE = OUT_LIVE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  input  logic par_i,
  input  logic last_i,
  output logic y_o
);
  logic y_live;
  assign y_live = last_i ? par_i : x_i;

  if (OUT_MODE == OUT_CLOCKED) begin : g_clocked
    logic y_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) y_q <= 1'b0;
      else         y_q <= y_live;
    end
    assign y_o = y_q;

    assert_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> y_o == $past(y_live));
  end else begin : g_live
    assign y_o = y_live;

    assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !last_i |-> y_o == x_i);
  end
endmodule

// File: rtl/serial_parity_inserter.sv
module serial_parity_inserter
  import parins_pkg::*;
#(
  parameter int unsigned DATA_BITS = 3,
  parameter out_mode_e   OUT_MODE  = OUT_LIVE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic y_o
);
  localparam int unsigned SLOT_W = $clog2(DATA_BITS + 1);

  logic [SLOT_W-1:0] slot;
  logic              par;
  logic              last;

  parins_state #(.DATA_BITS(DATA_BITS)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .slot_o (slot),
    .par_o  (par),
    .last_o (last)
  );

  parins_out_sel #(.OUT_MODE(OUT_MODE)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .par_i  (par),
    .last_i (last),
    .y_o    (y_o)
  );

  assert_parity_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_MODE == OUT_LIVE && slot == SLOT_W'(DATA_BITS)) |-> y_o == par);
endmodule

// File: tb/serial_parity_inserter_test.sv
module serial_parity_inserter_test;
  import parins_pkg::*;

  localparam int CLK_P = 10;
  localparam int NDATA = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic y_live, y_reg;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  int   slot = 0;
  logic par  = 1'b0;
  logic exp_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  serial_parity_inserter #(.DATA_BITS(NDATA), .OUT_MODE(OUT_LIVE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y_live));

  serial_parity_inserter #(.DATA_BITS(NDATA), .OUT_MODE(OUT_CLOCKED)) uut_reg (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y_reg));

  task automatic check(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic run_cycle(input logic xv);
    logic exp_live;
    x = xv;
    #(CLK_P/4);
    exp_live = (slot == NDATA) ? par : xv;
    check(y_live, exp_live, (slot == NDATA) ? "R3/R4/R5 parity slot" : "R1/R2 data slot");
    check(y_reg, exp_prev, "R7 clocked output");
    exp_prev = exp_live;
    if (slot == 0) begin
      par = xv; slot = 1;
    end else if (slot == NDATA) begin
      par = 1'b0; slot = 0;
    end else begin
      par = par ^ xv; slot++;
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [NDATA-1:0] d, input logic stuff);
    for (int i = 0; i < NDATA; i++) run_cycle(d[i]);
    run_cycle(stuff);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    x = 1'b1;
    #1;
    check(y_reg, 1'b0, "R6 reset clocked output");
    check(y_live, 1'b1, "R6 reset slot 0 passes input");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    slot = 0; par = 1'b0; exp_prev = 1'b0;
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();
    // all data patterns, both values on the ignored slot (R5)
    for (int p = 0; p < 8; p++) send_frame(3'(p), 1'b1);
    for (int p = 7; p >= 0; p--) send_frame(3'(p), 1'b0);
    // parity must not carry across frames (R4)
    send_frame(3'b001, 1'b1);
    send_frame(3'b000, 1'b1);
    lfsr = 16'hACE1;
    for (int f = 0; f < 40; f++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_frame(lfsr[2:0], lfsr[3]);
    end
    // reset in the middle of a frame, realign to slot 0 (R1, R6)
    run_cycle(1'b1);
    run_cycle(1'b0);
    do_reset();
    send_frame(3'b100, 1'b1);
    send_frame(3'b110, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule